// File: doc/BRIEF.md
# Guest Counter Access Permission Checker

This block decides whether an instruction may read one of the user-level counter CSRs. It also reports which exception to raise when the read is refused. It looks at the 12-bit CSR address, the current privilege level, the virtualization flag, a global enable for the counter extension, and two 32-bit counter-enable masks. The machine-level mask is always applied. The hypervisor-level mask is applied only while the hart runs as a guest.

A counter that the machine level allows but the hypervisor level blocks gives a virtual-instruction fault, cause 0x16. This lets the hypervisor emulate the access. A counter that the machine level blocks always gives an illegal-instruction fault, cause 0x2.

The block is purely combinational. It sits beside the CSR decode stage, and its verdict feeds the trap logic. With the `RV32` parameter set, the upper-half counter CSRs are checked as well.

Top module: `ctr_access_chk`

## Requirements
- R1: For any CSR address outside the counter ranges, `fault_o` is 0 and `cause_o` is 0.
- R2: For a counter address, when `ctr_ext_en_i` is 0, the block reports a fault with cause 0x02, whatever the other inputs are.
- R3: For a counter address, with the extension enabled, a privilege below machine (`priv_i` != 3) and the selected machine-mask bit clear, the block reports cause 0x02. This holds in either mode, so it wins over the hypervisor check.
- R4: In guest mode (`virt_i`=1), with the extension enabled, the machine bit set and the hypervisor bit clear, the block reports cause 0x16.
- R5: When `virt_i`=0, `hcounten_i` has no effect on the outputs.
- R6: The low counter CSRs map to mask bits as follows. Address 0xC00 (cycle) uses bit 0, 0xC01 (time) uses bit 1, and 0xC02 (retired instructions) uses bit 2. Performance counter N (N=3..31) at 0xC00+N uses bit N.
- R7: With `RV32`=1, the upper-half address 0xC80+N (N=0..31) is a counter and uses the same bit N as its lower half.
- R8: At machine privilege (`priv_i`=3) with `virt_i`=0 and the extension enabled, a counter read does not fault.
- R9: When `fault_o` is 0, `cause_o` is 0. When `fault_o` is 1, `cause_o` is 0x02 or 0x16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 12 | CSR address being read |
| virt_i | input | 1 | Hart runs virtualized (guest mode) |
| priv_i | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| ctr_ext_en_i | input | 1 | Counter extension enabled |
| mcounten_i | input | 32 | Machine-level counter-enable mask |
| hcounten_i | input | 32 | Hypervisor-level counter-enable mask |
| fault_o | output | 1 | Access refused |
| cause_o | output | 5 | Exception cause code, 0 when no fault |

## Verification
Every one of the 64 counter addresses is applied with random masks in both modes and at random privileges.
- The runs with the extension off isolate R2.
- Random hypervisor masks in host mode show that mask is ignored (R5).
- Walking one-hot masks on the low and high halves pin the bit mapping, so an off-by-one or a swapped mask shows up as a wrong cause.
- Addresses just outside each range, and the case where both mask bits are clear in guest mode, separate "no counter" from the machine-over-hypervisor priority.

// File: rtl/ctr_chk_pkg.sv
package ctr_chk_pkg;
  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned NUM_CTR = 32;
  localparam int unsigned IDX_W   = $clog2(NUM_CTR);
  localparam int unsigned CAUSE_W = 5;

  localparam logic [CSR_AW-1:0] CTR_LO_BASE = 12'hC00;
  localparam logic [CSR_AW-1:0] CTR_HI_BASE = 12'hC80;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 5'h00;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'h02;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'h16;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef struct packed {
    logic               fault;
    logic [CAUSE_W-1:0] cause;
  } verdict_t;
endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
  import ctr_chk_pkg::*;
#(
  parameter bit RV32 = 1'b1
) (
  input  logic [CSR_AW-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic lo_hit, hi_hit;

  // bases are aligned to NUM_CTR, so upper bits select the window
  assign lo_hit = (addr_i[CSR_AW-1:IDX_W] == CTR_LO_BASE[CSR_AW-1:IDX_W]);

  generate
    if (RV32) begin : g_hi
      assign hi_hit = (addr_i[CSR_AW-1:IDX_W] == CTR_HI_BASE[CSR_AW-1:IDX_W]);
    end else begin : g_no_hi
      assign hi_hit = 1'b0;
    end
  endgenerate

  assign hit_o = lo_hit | hi_hit;
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/ctr_enable_pick.sv
module ctr_enable_pick
  import ctr_chk_pkg::*;
(
  input  logic [NUM_CTR-1:0] m_mask_i,
  input  logic [NUM_CTR-1:0] h_mask_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               m_bit_o,
  output logic               h_bit_o
);
  logic [NUM_CTR-1:0] sel;

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_sel
      assign sel[i] = (idx_i == IDX_W'(i));
    end
  endgenerate

  assign m_bit_o = |(sel & m_mask_i);
  assign h_bit_o = |(sel & h_mask_i);
endmodule

// File: rtl/ctr_verdict.sv
module ctr_verdict
  import ctr_chk_pkg::*;
(
  input  logic     hit_i,
  input  logic     ext_en_i,
  input  logic     virt_i,
  input  priv_e    priv_i,
  input  logic     m_bit_i,
  input  logic     h_bit_i,
  output verdict_t verdict_o
);
  always_comb begin
    verdict_o = '{fault: 1'b0, cause: CAUSE_NONE};
    if (hit_i) begin
      if (!ext_en_i) begin
        verdict_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
      end else if (priv_i != PRIV_M && !m_bit_i) begin
        // machine gate outranks the guest gate
        verdict_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
      end else if (virt_i && m_bit_i && !h_bit_i) begin
        verdict_o = '{fault: 1'b1, cause: CAUSE_VIRT};
      end
    end
  end
endmodule

// File: rtl/ctr_access_chk.sv
module ctr_access_chk
  import ctr_chk_pkg::*;
#(
  parameter bit RV32 = 1'b1
) (
  input  logic [11:0] addr_i,
  input  logic        virt_i,
  input  logic [1:0]  priv_i,
  input  logic        ctr_ext_en_i,
  input  logic [31:0] mcounten_i,
  input  logic [31:0] hcounten_i,
  output logic        fault_o,
  output logic [4:0]  cause_o
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             m_bit, h_bit;
  verdict_t         verdict;

  ctr_addr_decode #(.RV32(RV32)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  ctr_enable_pick u_pick (
    .m_mask_i (mcounten_i),
    .h_mask_i (hcounten_i),
    .idx_i    (idx),
    .m_bit_o  (m_bit),
    .h_bit_o  (h_bit)
  );

  ctr_verdict u_verdict (
    .hit_i     (hit),
    .ext_en_i  (ctr_ext_en_i),
    .virt_i    (virt_i),
    .priv_i    (priv_e'(priv_i)),
    .m_bit_i   (m_bit),
    .h_bit_i   (h_bit),
    .verdict_o (verdict)
  );

  assign fault_o = verdict.fault;
  assign cause_o = verdict.cause;
endmodule

// File: rtl/ctr_access_chk_sva.sv
module ctr_access_chk_sva #(
  parameter bit RV32 = 1'b1
) (
  input logic [11:0] addr_i,
  input logic        virt_i,
  input logic [1:0]  priv_i,
  input logic        ctr_ext_en_i,
  input logic [31:0] mcounten_i,
  input logic [31:0] hcounten_i,
  input logic        fault_o,
  input logic [4:0]  cause_o
);
  logic is_ctr;
  assign is_ctr = (addr_i >= 12'hC00 && addr_i <= 12'hC1F) ||
                  (RV32 && addr_i >= 12'hC80 && addr_i <= 12'hC9F);

  always_comb begin
    if (!$isunknown({addr_i, virt_i, priv_i, ctr_ext_en_i, mcounten_i, hcounten_i})) begin
      AST_CAUSE_LEGAL: assert (!fault_o || cause_o == 5'h02 || cause_o == 5'h16); // R9
      AST_IDLE_CAUSE: assert (fault_o || cause_o == 5'h00); // R9
      AST_NONCTR_QUIET: assert (is_ctr || !fault_o); // R1
      AST_EXT_OFF_ILLEGAL: assert (!(is_ctr && !ctr_ext_en_i) || (fault_o && cause_o == 5'h02)); // R2
      AST_VIRT_ONLY: assert (!(fault_o && cause_o == 5'h16) || virt_i); // R4
      AST_HOST_MACHINE: assert (!(is_ctr && ctr_ext_en_i && !virt_i && priv_i == 2'd3) || !fault_o); // R8
    end
  end
endmodule

bind ctr_access_chk ctr_access_chk_sva #(.RV32(RV32)) u_sva (.*);

// File: tb/sim_ctr_access_chk.sv
`timescale 1ns/1ps
module sim_ctr_access_chk;
  localparam bit RV32 = 1'b1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr;
  logic        virt;
  logic [1:0]  priv;
  logic        ext_en;
  logic [31:0] m_mask, h_mask;
  logic        fault;
  logic [4:0]  cause;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [11:0] addr;
    logic        fault;
    logic [4:0]  cause;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  ctr_access_chk #(.RV32(RV32)) u0 (
    .addr_i       (addr),
    .virt_i       (virt),
    .priv_i       (priv),
    .ctr_ext_en_i (ext_en),
    .mcounten_i   (m_mask),
    .hcounten_i   (h_mask),
    .fault_o      (fault),
    .cause_o      (cause)
  );

  function automatic exp_t model(logic [11:0] a, logic v, logic [1:0] p, logic e,
                                 logic [31:0] m, logic [31:0] h);
    exp_t r;
    bit lo, hi;
    int n;
    r.addr = a; r.fault = 1'b0; r.cause = 5'h00;
    lo = (a >= 12'hC00 && a <= 12'hC1F);
    hi = RV32 && (a >= 12'hC80 && a <= 12'hC9F);
    if (!lo && !hi) begin r.tag = "R1"; return r; end
    n = lo ? int'(a - 12'hC00) : int'(a - 12'hC80);
    if (!e) begin
      r.fault = 1'b1; r.cause = 5'h02; r.tag = "R2";
    end else if (p != 2'd3 && !m[n]) begin
      r.fault = 1'b1; r.cause = 5'h02; r.tag = "R3";
    end else if (v && m[n] && !h[n]) begin
      r.fault = 1'b1; r.cause = 5'h16; r.tag = "R4";
    end else if (!v && p == 2'd3) begin
      r.tag = "R8";
    end else if (!v) begin
      r.tag = "R5";
    end else begin
      r.tag = hi ? "R7" : "R6";
    end
    return r;
  endfunction

  task automatic apply(logic [11:0] a, logic v, logic [1:0] p, logic e,
                       logic [31:0] m, logic [31:0] h, string tag_ovr);
    exp_t x;
    @(posedge clk);
    addr = a; virt = v; priv = p; ext_en = e; m_mask = m; h_mask = h;
    x = model(a, v, p, e, m, h);
    if (tag_ovr != "") x.tag = tag_ovr;
    sb.push_back(x);
  endtask

  // monitor: compare at the falling edge after each drive
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      n_checks++;
      if (fault !== x.fault || cause !== x.cause) begin
        n_errors++;
        $display("FAIL %s addr=%h fault=%0b cause=%h expected fault=%0b cause=%h",
                 x.tag, x.addr, fault, cause, x.fault, x.cause);
      end
      n_checks++;
      if (!((fault === 1'b0 && cause === 5'h00) ||
            (fault === 1'b1 && (cause === 5'h02 || cause === 5'h16)))) begin
        n_errors++;
        $display("FAIL R9 addr=%h fault=%0b cause=%h expected consistent pair",
                 x.addr, fault, cause);
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    addr = '0; virt = 0; priv = 0; ext_en = 0; m_mask = '0; h_mask = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state check, non-counter address (R1)
    apply(12'h000, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, "R1");

    // non-counter neighbours (R1)
    apply(12'hC20, 1'b1, 2'd0, 1'b1, 32'h0, 32'h0, "R1");
    apply(12'hBFF, 1'b1, 2'd0, 1'b0, 32'h0, 32'h0, "R1");
    apply(12'hC7F, 1'b0, 2'd1, 1'b0, 32'h0, 32'h0, "R1");
    apply(12'hCA0, 1'b1, 2'd1, 1'b0, 32'h0, 32'h0, "R1");
    apply(12'hB00, 1'b1, 2'd0, 1'b1, 32'h0, 32'h0, "R1");

    // one-hot walks in guest mode: only the selected bit matters (R6, R7)
    for (int n = 0; n < 32; n++) begin
      apply(12'hC00 + 12'(n), 1'b1, 2'd1, 1'b1, 32'h1 << n, 32'h1 << n, "R6");
      apply(12'hC00 + 12'(n), 1'b1, 2'd1, 1'b1, ~(32'h1 << n), 32'hFFFF_FFFF, "R6");
      apply(12'hC00 + 12'(n), 1'b1, 2'd1, 1'b1, 32'hFFFF_FFFF, ~(32'h1 << n), "R6");
      apply(12'hC80 + 12'(n), 1'b1, 2'd0, 1'b1, 32'h1 << n, 32'h1 << n, "R7");
      apply(12'hC80 + 12'(n), 1'b1, 2'd0, 1'b1, 32'hFFFF_FFFF, ~(32'h1 << n), "R7");
    end

    // both bits clear in guest mode: machine check wins (R3)
    apply(12'hC01, 1'b1, 2'd1, 1'b1, 32'h0, 32'h0, "R3");
    apply(12'hC9F, 1'b1, 2'd0, 1'b1, 32'h0, 32'h0, "R3");
    // machine mode, host, empty masks (R8)
    apply(12'hC02, 1'b0, 2'd3, 1'b1, 32'h0, 32'h0, "R8");
    // host mode: hypervisor mask toggled, result unchanged (R5)
    apply(12'hC05, 1'b0, 2'd1, 1'b1, 32'h20, 32'h0, "R5");
    apply(12'hC05, 1'b0, 2'd1, 1'b1, 32'h20, 32'hFFFF_FFFF, "R5");

    // sweep every counter address with random settings
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 64; i++) begin
        logic [11:0] a;
        a = (i < 32) ? 12'hC00 + 12'(i) : 12'hC80 + 12'(i - 32);
        apply(a, k[0], 2'($urandom), k != 7, $urandom, $urandom, "");
      end
    end

    @(posedge clk);
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule